// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block keeps the eight-bit status byte of a serial NOR flash device and decides, cycle by cycle, what each decoded instruction may do to it. An upstream instruction decoder delivers one-cycle strobes: latch set, latch clear, status write with a data byte, status read, single-byte program, the three phases of sequential-address programming (start, next word, finish), and erase of a sector, a block or the whole array. A separate flag travels with a program word and says that its address is the highest one not protected.

The controller tracks the write-enable latch and the protection and lock bits. It also tracks whether sequential programming is active, and whether an internal program or erase is running. The duration of each internal operation comes from a cycle counter whose length is a parameter per operation type, with whole-array erase the longest. Every accepted write-class instruction gives a one-cycle accept pulse. Every refused instruction gives a one-cycle reject pulse. The decoder is expected to raise at most one strobe per cycle. Serial shifting, the array itself and the mapping of protection levels to address ranges are handled elsewhere.

Top module: `flash_status_ctrl`

## Requirements
- R1: After reset the status byte is 0x1C and both the accept and reject pulses are 0.
- R2: Status byte layout: bit 0 busy, bit 1 write-enable latch, bits 5:2 protection level (bit 2 lowest), bit 6 sequential-programming mode, bit 7 protection lock.
- R3: When idle, a latch-set strobe sets bit 1. A latch-clear strobe clears bit 1 and also leaves sequential-programming mode.
- R4: A status write with the latch set loads bit 7 and bits 5:2 from the data byte, ignores data bits 6, 1 and 0, clears the latch, and pulses accept.
- R5: Byte program, any erase, or sequential-programming start with the latch clear is refused: reject pulses and busy stays 0.
- R6: A status write with the latch clear is refused: reject pulses and the status byte is unchanged.
- R7: While bit 7 is 1, a status write leaves bits 5:2 unchanged, while bit 7 itself is still loaded from the data.
- R8: While busy, every strobe except status read is ignored and gives a reject pulse. A status read never gives a reject pulse.
- R9: An accepted program or erase holds busy high for exactly its parameter count of cycles: T_PROG (byte or word program), T_SECT, T_BLK, T_CHIP. Busy starts in the cycle after acceptance.
- R10: The latch clears in the cycle that busy falls after a byte program, sector, block or array erase.
- R11: Sequential-programming start with the latch set enters the mode (bit 6) and programs a word. Next-word strobes are accepted only in that mode, and the latch stays set between words. Finish leaves the mode and clears the latch. Byte program, erase, status write and next-word strobes outside the mode are refused.
- R12: A program word issued with the top-address flag ends sequential-programming mode and clears the latch when its busy period ends.
- R13: Accept and reject are single-cycle registered pulses, appear in the cycle after the strobe, and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_wren | input | 1 | Latch-set strobe |
| op_wrdi | input | 1 | Latch-clear strobe |
| op_wrsr | input | 1 | Status-write strobe |
| wrsr_data | input | 8 | Data byte for status write |
| op_rdsr | input | 1 | Status-read strobe |
| op_byte_prog | input | 1 | Single-byte program strobe |
| op_seq_start | input | 1 | Sequential-programming start strobe (first word) |
| op_seq_next | input | 1 | Sequential-programming next-word strobe |
| op_seq_end | input | 1 | Sequential-programming finish strobe |
| top_addr_hit | input | 1 | Word being programmed is at the highest unprotected address |
| op_sect_erase | input | 1 | Sector erase strobe |
| op_blk_erase | input | 1 | Block erase strobe |
| op_chip_erase | input | 1 | Whole-array erase strobe |
| status_byte | output | 8 | Current status byte |
| cmd_accept | output | 1 | Pulse: previous-cycle instruction accepted |
| cmd_reject | output | 1 | Pulse: previous-cycle instruction refused |

## Verification
The hardest state to reach is the automatic end of sequential programming. It needs a latch set, an accepted start, a full busy period, and then a next-word strobe carrying the top-address flag. Only when that word's busy period ends do bit 6 and bit 1 both fall together. The stimulus walks through that chain with the operation counts shortened by parameter. It also crosses the lock bit with status writes, so that protection bits are shown frozen while the lock itself is cleared by the same write.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_BYTE = 3'd1,
    OP_WORD = 3'd2,
    OP_SECT = 3'd3,
    OP_BLK  = 3'd4,
    OP_CHIP = 3'd5
  } op_e;

  localparam int SB_BUSY = 0;
  localparam int SB_WEL  = 1;
  localparam int SB_BPLO = 2;
  localparam int SB_BPHI = 5;
  localparam int SB_SEQ  = 6;
  localparam int SB_LOCK = 7;
endpackage

// File: rtl/flash_op_timer.sv
module flash_op_timer
  import flash_status_pkg::*;
#(
  parameter int T_PROG = 8,
  parameter int T_SECT = 16,
  parameter int T_BLK  = 32,
  parameter int T_CHIP = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  op_e  start_op,
  input  logic start_top,
  output logic busy,
  output logic done,
  output op_e  cur_op,
  output logic cur_top
);
  localparam int CW = $clog2(T_CHIP + 1);
  localparam logic [CW-1:0] L_PROG = CW'(T_PROG - 1);
  localparam logic [CW-1:0] L_SECT = CW'(T_SECT - 1);
  localparam logic [CW-1:0] L_BLK  = CW'(T_BLK - 1);
  localparam logic [CW-1:0] L_CHIP = CW'(T_CHIP - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] load_val;

  always_comb begin
    case (start_op)
      OP_SECT: load_val = L_SECT;
      OP_BLK:  load_val = L_BLK;
      OP_CHIP: load_val = L_CHIP;
      default: load_val = L_PROG;
    endcase
  end

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt     <= '0;
      cur_op  <= OP_NONE;
      cur_top <= 1'b0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      cnt     <= load_val;
      cur_op  <= start_op;
      cur_top <= start_top;
    end else if (done) begin
      busy    <= 1'b0;
      cur_op  <= OP_NONE;
      cur_top <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  p_cnt_range_r9: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= L_CHIP));
  p_done_ends_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
  p_start_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
endmodule

// File: rtl/flash_cmd_gate.sv
module flash_cmd_gate
  import flash_status_pkg::*;
(
  input  logic busy,
  input  logic wel,
  input  logic seq_mode,
  input  logic op_wren,
  input  logic op_wrdi,
  input  logic op_wrsr,
  input  logic op_rdsr,
  input  logic op_byte_prog,
  input  logic op_seq_start,
  input  logic op_seq_next,
  input  logic op_seq_end,
  input  logic op_sect_erase,
  input  logic op_blk_erase,
  input  logic op_chip_erase,
  output logic g_wren,
  output logic g_wrdi,
  output logic g_wrsr,
  output logic g_seq_end,
  output logic g_start,
  output logic g_seq_enter,
  output op_e  start_op,
  output logic accept,
  output logic reject
);
  logic any_strobe, mem_cmd, mem_ok;

  assign any_strobe = op_wren | op_wrdi | op_wrsr | op_byte_prog | op_seq_start |
                      op_seq_next | op_seq_end | op_sect_erase | op_blk_erase |
                      op_chip_erase;
  assign mem_cmd = op_byte_prog | op_seq_start | op_sect_erase | op_blk_erase |
                   op_chip_erase;
  assign mem_ok  = wel && !seq_mode;

  always_comb begin
    g_wren      = !busy && op_wren;
    g_wrdi      = !busy && op_wrdi;
    g_wrsr      = !busy && op_wrsr && mem_ok;
    g_seq_end   = !busy && op_seq_end && seq_mode;
    g_seq_enter = !busy && op_seq_start && mem_ok;
    g_start     = !busy && ((mem_cmd && mem_ok) || (op_seq_next && seq_mode));
    if (op_sect_erase)      start_op = OP_SECT;
    else if (op_blk_erase)  start_op = OP_BLK;
    else if (op_chip_erase) start_op = OP_CHIP;
    else if (op_byte_prog)  start_op = OP_BYTE;
    else                    start_op = OP_WORD;
    accept = g_wrsr | g_seq_end | g_start;
    if (busy)
      reject = any_strobe;
    else
      reject = (op_wrsr && !mem_ok) || (mem_cmd && !mem_ok) ||
               ((op_seq_next || op_seq_end) && !seq_mode);
  end

  always_comb begin
    assert (!(accept && reject));
    assert (!(op_rdsr && !any_strobe && (accept || reject)));
  end
endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import flash_status_pkg::*;
#(
  parameter int T_PROG = 8,
  parameter int T_SECT = 16,
  parameter int T_BLK  = 32,
  parameter int T_CHIP = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       op_wren,
  input  logic       op_wrdi,
  input  logic       op_wrsr,
  input  logic [7:0] wrsr_data,
  input  logic       op_rdsr,
  input  logic       op_byte_prog,
  input  logic       op_seq_start,
  input  logic       op_seq_next,
  input  logic       op_seq_end,
  input  logic       top_addr_hit,
  input  logic       op_sect_erase,
  input  logic       op_blk_erase,
  input  logic       op_chip_erase,
  output logic [7:0] status_byte,
  output logic       cmd_accept,
  output logic       cmd_reject
);
  localparam int BPW = SB_BPHI - SB_BPLO + 1;
  localparam logic [BPW-1:0] BP_RESET = BPW'(4'b0111);

  logic           wel_q, seq_q, lock_q;
  logic [BPW-1:0] bp_q;
  logic           busy, done, cur_top;
  op_e            cur_op, start_op;
  logic           g_wren, g_wrdi, g_wrsr, g_seq_end, g_start, g_seq_enter;
  logic           acc_d, rej_d;

  flash_cmd_gate u_gate (
    .busy(busy), .wel(wel_q), .seq_mode(seq_q),
    .op_wren(op_wren), .op_wrdi(op_wrdi), .op_wrsr(op_wrsr), .op_rdsr(op_rdsr),
    .op_byte_prog(op_byte_prog), .op_seq_start(op_seq_start),
    .op_seq_next(op_seq_next), .op_seq_end(op_seq_end),
    .op_sect_erase(op_sect_erase), .op_blk_erase(op_blk_erase),
    .op_chip_erase(op_chip_erase),
    .g_wren(g_wren), .g_wrdi(g_wrdi), .g_wrsr(g_wrsr), .g_seq_end(g_seq_end),
    .g_start(g_start), .g_seq_enter(g_seq_enter), .start_op(start_op),
    .accept(acc_d), .reject(rej_d)
  );

  flash_op_timer #(
    .T_PROG(T_PROG), .T_SECT(T_SECT), .T_BLK(T_BLK), .T_CHIP(T_CHIP)
  ) u_timer (
    .clk(clk), .rst(rst), .start(g_start), .start_op(start_op),
    .start_top(top_addr_hit), .busy(busy), .done(done),
    .cur_op(cur_op), .cur_top(cur_top)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q      <= 1'b0;
      seq_q      <= 1'b0;
      lock_q     <= 1'b0;
      bp_q       <= BP_RESET;
      cmd_accept <= 1'b0;
      cmd_reject <= 1'b0;
    end else begin
      cmd_accept <= acc_d;
      cmd_reject <= rej_d;
      if (done) begin
        if (cur_op == OP_WORD) begin
          if (cur_top) begin
            seq_q <= 1'b0;
            wel_q <= 1'b0;
          end
        end else begin
          wel_q <= 1'b0;
        end
      end
      if (g_wren) wel_q <= 1'b1;
      if (g_wrdi || g_seq_end) begin
        wel_q <= 1'b0;
        seq_q <= 1'b0;
      end
      if (g_seq_enter) seq_q <= 1'b1;
      if (g_wrsr) begin
        wel_q  <= 1'b0;
        lock_q <= wrsr_data[SB_LOCK];
        if (!lock_q) bp_q <= wrsr_data[SB_BPHI:SB_BPLO];
      end
    end
  end

  assign status_byte = {lock_q, seq_q, bp_q, wel_q, busy};

  p_lock_holds_bp_r7: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> $stable(bp_q));
  p_busy_refuses_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && (op_wren || op_wrdi || op_wrsr || op_byte_prog || op_seq_start ||
              op_seq_next || op_seq_end || op_sect_erase || op_blk_erase ||
              op_chip_erase)) |=> (cmd_reject && !cmd_accept));
  p_no_start_unlatched_r5: assert property (@(posedge clk) disable iff (rst)
    (!busy && !wel_q && (op_byte_prog || op_seq_start || op_sect_erase ||
                         op_blk_erase || op_chip_erase)) |=> !busy);
  p_wel_clears_done_r10: assert property (@(posedge clk) disable iff (rst)
    (done && cur_op != OP_WORD) |=> !wel_q);
  p_top_ends_seq_r12: assert property (@(posedge clk) disable iff (rst)
    (done && cur_op == OP_WORD && cur_top) |=> (!seq_q && !wel_q));
  p_pulse_excl_r13: assert property (@(posedge clk) disable iff (rst)
    !(cmd_accept && cmd_reject));
  p_seq_needs_wel_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(seq_q) |-> ($past(wel_q) && busy));
endmodule

// File: tb/flash_status_ctrl_test.sv
module flash_status_ctrl_test;
  localparam int TP = 3, TS = 5, TB = 7, TC = 11;
  localparam int C_WREN = 0, C_WRDI = 1, C_WRSR = 2, C_RDSR = 3, C_BYTE = 4,
                 C_SSTART = 5, C_SNEXT = 6, C_SEND = 7, C_SECT = 8, C_BLK = 9,
                 C_CHIP = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic op_wren = 0, op_wrdi = 0, op_wrsr = 0, op_rdsr = 0, op_byte_prog = 0;
  logic op_seq_start = 0, op_seq_next = 0, op_seq_end = 0, top_addr_hit = 0;
  logic op_sect_erase = 0, op_blk_erase = 0, op_chip_erase = 0;
  logic [7:0] wrsr_data = 8'h00;
  logic [7:0] status_byte;
  logic cmd_accept, cmd_reject;

  always #5 clk = ~clk;

  flash_status_ctrl #(.T_PROG(TP), .T_SECT(TS), .T_BLK(TB), .T_CHIP(TC)) uut (
    .clk(clk), .rst(rst), .op_wren(op_wren), .op_wrdi(op_wrdi), .op_wrsr(op_wrsr),
    .wrsr_data(wrsr_data), .op_rdsr(op_rdsr), .op_byte_prog(op_byte_prog),
    .op_seq_start(op_seq_start), .op_seq_next(op_seq_next), .op_seq_end(op_seq_end),
    .top_addr_hit(top_addr_hit), .op_sect_erase(op_sect_erase),
    .op_blk_erase(op_blk_erase), .op_chip_erase(op_chip_erase),
    .status_byte(status_byte), .cmd_accept(cmd_accept), .cmd_reject(cmd_reject)
  );

  typedef struct {
    int         due;
    logic [7:0] st;
    logic       acc;
    logic       rej;
    string      req;
  } exp_t;

  exp_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input int got, input int exp, input string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", what, got, exp);
    end
  endtask

  // monitor: pops expected items when due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      chk(status_byte, e.st, {e.req, " status"});
      chk(cmd_accept, e.acc, {e.req, " accept"});
      chk(cmd_reject, e.rej, {e.req, " reject"});
    end
  end

  task automatic clear_in();
    op_wren = 0; op_wrdi = 0; op_wrsr = 0; op_rdsr = 0; op_byte_prog = 0;
    op_seq_start = 0; op_seq_next = 0; op_seq_end = 0; top_addr_hit = 0;
    op_sect_erase = 0; op_blk_erase = 0; op_chip_erase = 0;
  endtask

  // driver: one strobe, expected outputs pushed to the scoreboard
  task automatic issue(input int c, input logic [7:0] d, input logic top,
                       input logic [7:0] es, input logic ea, input logic er,
                       input string req);
    exp_t e;
    @(negedge clk);
    wrsr_data = d; top_addr_hit = top;
    case (c)
      C_WREN:   op_wren = 1;
      C_WRDI:   op_wrdi = 1;
      C_WRSR:   op_wrsr = 1;
      C_RDSR:   op_rdsr = 1;
      C_BYTE:   op_byte_prog = 1;
      C_SSTART: op_seq_start = 1;
      C_SNEXT:  op_seq_next = 1;
      C_SEND:   op_seq_end = 1;
      C_SECT:   op_sect_erase = 1;
      C_BLK:    op_blk_erase = 1;
      default:  op_chip_erase = 1;
    endcase
    e.due = cyc + 1; e.st = es; e.acc = ea; e.rej = er; e.req = req;
    q.push_back(e);
    @(negedge clk);
    clear_in();
  endtask

  // counts busy cycles from the current negedge, then checks final status
  task automatic busy_len(input int exp_len, input logic [7:0] after, input string req);
    int n = 0;
    while (status_byte[0] && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(n, exp_len, {req, " busy length"});
    chk(status_byte, after, {req, " status after busy"});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(status_byte, 8'h1C, "R1 R2 reset status");
    chk(cmd_accept, 0, "R1 reset accept");
    chk(cmd_reject, 0, "R1 reset reject");

    issue(C_BYTE, 0, 0, 8'h1C, 0, 1, "R5 byte program unlatched");
    issue(C_SECT, 0, 0, 8'h1C, 0, 1, "R5 sector erase unlatched");
    issue(C_SSTART, 0, 0, 8'h1C, 0, 1, "R5 seq start unlatched");
    issue(C_WREN, 0, 0, 8'h1E, 0, 0, "R3 latch set");
    issue(C_WRSR, 8'h43, 0, 8'h00, 1, 0, "R4 status write ignores 6,1,0");
    issue(C_WRSR, 8'hFF, 0, 8'h00, 0, 1, "R6 status write unlatched");
    issue(C_WREN, 0, 0, 8'h02, 0, 0, "R3 latch set");
    issue(C_WRSR, 8'hBC, 0, 8'hBC, 1, 0, "R7 set lock");
    issue(C_WREN, 0, 0, 8'hBE, 0, 0, "R3 latch set");
    issue(C_WRSR, 8'h00, 0, 8'h3C, 1, 0, "R7 protection frozen, lock cleared");
    issue(C_WREN, 0, 0, 8'h3E, 0, 0, "R3 latch set");
    issue(C_WRDI, 0, 0, 8'h3C, 0, 0, "R3 latch clear");

    issue(C_WREN, 0, 0, 8'h3E, 0, 0, "R3 latch set");
    issue(C_BYTE, 0, 0, 8'h3F, 1, 0, "R13 byte program accepted");
    busy_len(TP, 8'h3C, "R9 R10 byte program");
    issue(C_WREN, 0, 0, 8'h3E, 0, 0, "R3 latch set");
    issue(C_SECT, 0, 0, 8'h3F, 1, 0, "R13 sector erase accepted");
    busy_len(TS, 8'h3C, "R9 R10 sector erase");
    issue(C_WREN, 0, 0, 8'h3E, 0, 0, "R3 latch set");
    issue(C_BLK, 0, 0, 8'h3F, 1, 0, "R13 block erase accepted");
    busy_len(TB, 8'h3C, "R9 R10 block erase");
    issue(C_WREN, 0, 0, 8'h3E, 0, 0, "R3 latch set");
    issue(C_CHIP, 0, 0, 8'h3F, 1, 0, "R13 array erase accepted");
    busy_len(TC, 8'h3C, "R9 R10 array erase");

    issue(C_WREN, 0, 0, 8'h3E, 0, 0, "R3 latch set");
    issue(C_CHIP, 0, 0, 8'h3F, 1, 0, "R8 array erase");
    issue(C_WRDI, 0, 0, 8'h3F, 0, 1, "R8 latch clear refused while busy");
    issue(C_WRSR, 8'h00, 0, 8'h3F, 0, 1, "R8 status write refused while busy");
    issue(C_RDSR, 0, 0, 8'h3F, 0, 0, "R8 status read allowed while busy");
    busy_len(TC - 6, 8'h3C, "R8 R10 array erase tail");

    issue(C_SNEXT, 0, 0, 8'h3C, 0, 1, "R11 next word outside mode");
    issue(C_WREN, 0, 0, 8'h3E, 0, 0, "R3 latch set");
    issue(C_SSTART, 0, 0, 8'h7F, 1, 0, "R11 seq start");
    busy_len(TP, 8'h7E, "R11 first word");
    issue(C_BYTE, 0, 0, 8'h7E, 0, 1, "R11 byte program in mode");
    issue(C_WRSR, 8'h00, 0, 8'h7E, 0, 1, "R11 status write in mode");
    issue(C_SNEXT, 0, 0, 8'h7F, 1, 0, "R11 next word");
    busy_len(TP, 8'h7E, "R11 latch kept after word");
    issue(C_SEND, 0, 0, 8'h3C, 1, 0, "R11 finish");

    issue(C_WREN, 0, 0, 8'h3E, 0, 0, "R3 latch set");
    issue(C_SSTART, 0, 0, 8'h7F, 1, 0, "R12 seq start");
    busy_len(TP, 8'h7E, "R12 first word");
    issue(C_SNEXT, 0, 1, 8'h7F, 1, 0, "R12 top word");
    busy_len(TP, 8'h3C, "R12 auto end at top address");

    issue(C_WREN, 0, 0, 8'h3E, 0, 0, "R3 latch set");
    issue(C_SSTART, 0, 0, 8'h7F, 1, 0, "R3 seq start");
    busy_len(TP, 8'h7E, "R3 first word");
    issue(C_WRDI, 0, 0, 8'h3C, 0, 0, "R3 latch clear ends mode");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule